// File: doc/BRIEF.md
# Offset Trim Search Controller

This block finds a binary offset trim code for one converter channel by successive approximation against an external comparator. A single start pulse puts the channel into calibration: the controller raises a calibration-enable line, asks the data path to hold the channel input at midscale, and drives a sequence of candidate trim codes. Each candidate is held for a programmable settle window before the comparator flag is sampled. The flag decides whether the next candidate moves down or up.

After the halving steps run out, the controller makes one last probe at the resulting code. It may nudge the code up by one. It then releases calibration mode, pulses done, and keeps the final code on its trim output until the next accepted start. The comparator, the midscale data forcing and the saving of the channel's output mode sit outside this block. They are steered by its `cal_en` and `force_mid` outputs.

Top module: `trim_search_ctrl`

## Requirements
- R1: After reset, trim is 0 and cal_en, force_mid, busy and done are all 0.
- R2: A start sampled high while idle makes busy, cal_en and force_mid 1 from the next cycle on. The first candidate on trim is half the code range (16 for a 5-bit trim).
- R3: Each candidate stays on trim for exactly settle_cnt+1 cycles, and cal_flag is sampled in the last of them. settle_cnt is captured each time a new candidate is applied.
- R4: In the halving phase the first step is a quarter of the code range (8 for a 5-bit trim). A sampled flag of 1 subtracts the step from trim, and a flag of 0 adds it. The step then halves, and the phase ends after the step-of-one move.
- R5: One final probe follows the halving phase. If its flag is 0, trim rises by one, saturating at the top code (31). If the flag is 1, trim is unchanged.
- R6: A calibration always takes five probes, so done is 1 exactly 5*(settle_cnt+1) cycles after the edge that accepted start.
- R7: done is a single-cycle pulse, and busy, cal_en and force_mid are 0 in the cycle done is 1.
- R8: After done, trim keeps the final code while no start is accepted.
- R9: A start raised while busy is ignored: the search sequence and its duration are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a calibration (honoured only when idle) |
| cal_flag | input | 1 | Comparator result; 1 means the current code is too high |
| settle_cnt | input | SETTLE_W | Extra settle cycles per candidate |
| trim | output | TRIM_W | Candidate or final trim code |
| cal_en | output | 1 | Calibration mode enable for the channel |
| force_mid | output | 1 | Hold channel data at midscale |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with its default parameters: a 5-bit trim, an 8-bit settle counter and saturating final increment. With these values every comparator threshold from 0 to 32 can be swept, so both extremes of the search are reached: a flag that is always high, which ends at code 1, and a flag that is always low, which pushes the final increment into saturation at 31. Settle counts of 0, 3 and 255 cover the shortest window, a window whose hold can be seen cycle by cycle, and the top of the settle counter.

// File: rtl/trim_cal_pkg.sv
package trim_cal_pkg;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_SEARCH = 2'd1,
      ST_FINAL  = 2'd2
   } cal_state_e;

endpackage

// File: rtl/trim_settle_timer.sv
module trim_settle_timer #(
   parameter int SETTLE_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load,
   input  logic [SETTLE_W-1:0] load_val,
   output logic                expired
);

   generate
      if (SETTLE_W < 1) begin : g_bad_w
         $error("SETTLE_W must be at least 1");
      end
   endgenerate

   logic [SETTLE_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expired = (cnt_q == '0);

   // R3: a freshly loaded window never expires in the same cycle unless loaded with zero
   p_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (expired == ($past(load_val) == '0)));

endmodule

// File: rtl/trim_step_unit.sv
module trim_step_unit #(
   parameter int TRIM_W    = 5,
   parameter bit SAT_FINAL = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              init,
   input  logic              adjust,
   input  logic              final_adj,
   input  logic              flag,
   output logic [TRIM_W-1:0] trim,
   output logic              step_last
);

   localparam logic [TRIM_W-1:0] MID_CODE   = TRIM_W'(1) << (TRIM_W - 1);
   localparam logic [TRIM_W-1:0] FIRST_STEP = MID_CODE >> 1;
   localparam logic [TRIM_W-1:0] TOP_CODE   = '1;

   generate
      if (TRIM_W < 2) begin : g_bad_w
         $error("TRIM_W must be at least 2");
      end
   endgenerate

   logic [TRIM_W-1:0] trim_q;
   logic [TRIM_W-1:0] step_q;
   logic [TRIM_W-1:0] bumped;

   generate
      if (SAT_FINAL) begin : g_sat
         assign bumped = (trim_q == TOP_CODE) ? trim_q : trim_q + 1'b1;
      end else begin : g_wrap
         assign bumped = trim_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trim_q <= '0;
         step_q <= '0;
      end else if (init) begin
         trim_q <= MID_CODE;
         step_q <= FIRST_STEP;
      end else if (adjust) begin
         trim_q <= flag ? (trim_q - step_q) : (trim_q + step_q);
         step_q <= step_q >> 1;
      end else if (final_adj) begin
         if (!flag) begin
            trim_q <= bumped;
         end
      end
   end

   assign trim      = trim_q;
   assign step_last = (step_q == TRIM_W'(1));

   // R4: step is a single power of two or zero
   p_step_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(step_q));

   // R4: a high flag during halving always lowers the code
   p_down_on_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (adjust && flag && !init) |=> (trim_q < $past(trim_q)));

   // R5: a high flag on the final probe leaves the code alone
   p_final_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (final_adj && flag && !init && !adjust) |=> $stable(trim_q));

endmodule

// File: rtl/trim_seq_fsm.sv
module trim_seq_fsm
   import trim_cal_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic window_over,
   input  logic step_last,
   output logic timer_load,
   output logic step_init,
   output logic step_adjust,
   output logic step_final,
   output logic active,
   output logic done
);

   cal_state_e st_q;
   cal_state_e st_d;
   logic       done_q;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_IDLE:   if (start) st_d = ST_SEARCH;
         ST_SEARCH: if (window_over && step_last) st_d = ST_FINAL;
         ST_FINAL:  if (window_over) st_d = ST_IDLE;
         default:   st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         done_q <= 1'b0;
      end else begin
         st_q   <= st_d;
         done_q <= (st_q == ST_FINAL) && window_over;
      end
   end

   assign step_init   = (st_q == ST_IDLE) && start;
   assign step_adjust = (st_q == ST_SEARCH) && window_over;
   assign step_final  = (st_q == ST_FINAL) && window_over;
   assign timer_load  = step_init || step_adjust;
   assign active      = (st_q != ST_IDLE);
   assign done        = done_q;

   // R9: a start during an unfinished window does not disturb the search
   p_busy_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_SEARCH && start && !window_over) |=> (st_q == ST_SEARCH));

   // R7: done only follows the final probe
   p_done_after_final_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($past(st_q) == ST_FINAL));

endmodule

// File: rtl/trim_search_ctrl.sv
module trim_search_ctrl #(
   parameter int TRIM_W    = 5,
   parameter int SETTLE_W  = 8,
   parameter bit SAT_FINAL = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic                cal_flag,
   input  logic [SETTLE_W-1:0] settle_cnt,
   output logic [TRIM_W-1:0]   trim,
   output logic                cal_en,
   output logic                force_mid,
   output logic                busy,
   output logic                done
);

   localparam logic [TRIM_W-1:0] MID_CODE = TRIM_W'(1) << (TRIM_W - 1);

   logic timer_load;
   logic window_over;
   logic step_init;
   logic step_adjust;
   logic step_final;
   logic step_last;
   logic active;

   trim_settle_timer #(.SETTLE_W(SETTLE_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (timer_load),
      .load_val (settle_cnt),
      .expired  (window_over)
   );

   trim_step_unit #(.TRIM_W(TRIM_W), .SAT_FINAL(SAT_FINAL)) u_step (
      .clk       (clk),
      .rst_n     (rst_n),
      .init      (step_init),
      .adjust    (step_adjust),
      .final_adj (step_final),
      .flag      (cal_flag),
      .trim      (trim),
      .step_last (step_last)
   );

   trim_seq_fsm u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .window_over (window_over),
      .step_last   (step_last),
      .timer_load  (timer_load),
      .step_init   (step_init),
      .step_adjust (step_adjust),
      .step_final  (step_final),
      .active      (active),
      .done        (done)
   );

   assign busy      = active;
   assign cal_en    = active;
   assign force_mid = active;

   // R2: accepted start applies the midscale code with calibration mode on
   p_start_mid_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start) |=> (trim == MID_CODE && cal_en && force_mid));

   // R3: the code cannot move while a settle window is still running
   p_settle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !window_over) |=> $stable(trim));

   // R7: done is one cycle wide
   p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R7: calibration mode is released when done shows
   p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && !cal_en && !force_mid));

   // R8: the final code is held while idle without a new start
   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> $stable(trim));

endmodule

// File: tb/sim_trim_search_ctrl.sv
module sim_trim_search_ctrl;

   localparam int TRIM_W   = 5;
   localparam int SETTLE_W = 8;

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic                start = 1'b0;
   logic                cal_flag;
   logic [SETTLE_W-1:0] settle_cnt = '0;
   logic [TRIM_W-1:0]   trim;
   logic                cal_en;
   logic                force_mid;
   logic                busy;
   logic                done;

   int n_cmp = 0;
   int n_bad = 0;
   int thr   = 0;
   int cyc   = 0;

   always #2.5 clk = ~clk;

   // comparator model: flag high when the code is at or above the threshold
   always_comb cal_flag = (int'(trim) >= thr);

   trim_search_ctrl #(.TRIM_W(TRIM_W), .SETTLE_W(SETTLE_W)) u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .cal_flag   (cal_flag),
      .settle_cnt (settle_cnt),
      .trim       (trim),
      .cal_en     (cal_en),
      .force_mid  (force_mid),
      .busy       (busy),
      .done       (done)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int ref_result(input int t_thr);
      int t = 16;
      int s = 8;
      while (s != 0) begin
         t = (t >= t_thr) ? t - s : t + s;
         s = s / 2;
      end
      if (!(t >= t_thr) && t < 31) t = t + 1;
      return t;
   endfunction

   // runs one calibration; pokes start while busy at cycle poke (0 = never)
   task automatic run_cal(input int n, input int t_thr, input int poke, input string req);
      int c = 0;
      thr = t_thr;
      settle_cnt = SETTLE_W'(n);
      @(negedge clk);
      start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      chk(busy && cal_en && force_mid, "R2 mode on", int'({busy, cal_en, force_mid}), 7);
      chk(trim == 5'd16, "R2 first code", int'(trim), 16);
      while (!done && c < 20000) begin
         @(posedge clk);
         c++;
         @(negedge clk);
         start = (poke != 0 && c == poke);
      end
      start = 1'b0;
      chk(c == 5 * (n + 1), {req, " R6 duration"}, c, 5 * (n + 1));
      chk(int'(trim) == ref_result(t_thr), {req, " R4/R5 result"}, int'(trim), ref_result(t_thr));
      chk(!busy && !cal_en && !force_mid, "R7 released at done", int'({busy, cal_en, force_mid}), 0);
      @(negedge clk);
      chk(!done, "R7 done one cycle", int'(done), 0);
   endtask

   task automatic t_reset();
      chk(trim == '0, "R1 trim", int'(trim), 0);
      chk({cal_en, force_mid, busy, done} == 4'b0, "R1 controls",
          int'({cal_en, force_mid, busy, done}), 0);
   endtask

   task automatic t_settle_window();
      int c = 0;
      thr = 0;
      settle_cnt = 8'd3;
      @(negedge clk);
      start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      while (c < 8) begin
         @(posedge clk);
         c++;
         @(negedge clk);
         if (c == 3) chk(trim == 5'd16, "R3 held through window", int'(trim), 16);
         if (c == 4) chk(trim == 5'd8, "R3 moved after window, R4 high lowers", int'(trim), 8);
         if (c == 7) chk(trim == 5'd8, "R3 second window hold", int'(trim), 8);
         if (c == 8) chk(trim == 5'd4, "R4 step halves", int'(trim), 4);
      end
      while (!done && c < 100) begin
         @(posedge clk);
         c++;
         @(negedge clk);
      end
      chk(c == 20, "R6 duration settle 3", c, 20);
      chk(trim == 5'd1, "R5 high final keeps code", int'(trim), 1);
   endtask

   task automatic t_saturate();
      run_cal(0, 32, 0, "R5 saturate");
      chk(trim == 5'd31, "R5 top code", int'(trim), 31);
   endtask

   task automatic t_sweep();
      for (int k = 0; k <= 32; k++) begin
         run_cal(0, k, 0, "R4 sweep");
      end
   endtask

   task automatic t_busy_start();
      run_cal(2, 11, 4, "R9 start ignored");
   endtask

   task automatic t_hold();
      logic [TRIM_W-1:0] kept;
      run_cal(1, 20, 0, "R8 setup");
      kept = trim;
      thr = 0;
      for (int i = 0; i < 10; i++) @(negedge clk);
      chk(trim == kept, "R8 final code held", int'(trim), int'(kept));
      chk(!busy, "R8 stays idle", int'(busy), 0);
   endtask

   task automatic t_long_settle();
      run_cal(255, 7, 0, "R3 long settle");
   endtask

   initial begin
      while (cyc < 150000) begin
         @(posedge clk);
         cyc++;
      end
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_settle_window();
      t_saturate();
      t_sweep();
      t_busy_start();
      t_hold();
      t_long_settle();
      repeat (2) @(negedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule